// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers four interrupt sources, one raster event and three DMA channel completions, into a single level-sensitive interrupt request for the CPU. When the CPU runs its interrupt-acknowledge cycle, the block picks the highest-priority enabled pending source. It then places an 8-bit table-index vector on its vector output. The upper nibble of that vector comes from a register that software writes. Bits 3..1 name the serviced source, and bit 0 is always low.

The raster source is built inside the block from two video timing inputs. One part is a fixed event every 52 lines. The other part fires on a line number that software programs. The two parts are ORed into one pending flag. Software picks one of two clear policies. In auto-clear mode, each acknowledge retires the source it serviced. In manual mode, pending flags are retired only by writing ones to a status register. In both modes, the source each acknowledge served is recorded in that status register. An acknowledge that finds nothing enabled and pending is still answered, with the vector of DMA channel 0.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The vector is {vector register bits 7..4, 3-bit source code, 0}, so bit 0 of every vector is 0.
- R2: Source codes in bits 3..1 are: raster 3'b011 (low nibble 6), DMA2 3'b000 (0), DMA1 3'b001 (2), DMA0 3'b010 (4).
- R3: Among sources that are both pending and enabled, the raster source wins, then DMA2, then DMA1, then DMA0.
- R4: An acknowledge with no enabled source pending returns the DMA0 vector and logs DMA0 as serviced.
- R5: With vector register (address 0) bit 0 = 0, an acknowledge clears the pending flag of the source it served, DMA sources included.
- R6: With address 0 bit 0 = 1, an acknowledge clears nothing. Writing 1 to status bits 3..0 clears those flags, and bits written 0 have no effect.
- R7: Status (address 2) bits 3..0 show pending {raster, DMA2, DMA1, DMA0} from bit 3 down to bit 0. Bits 7..4 hold a one-hot of the last serviced source in the same order. Read data is registered and appears one clock after the address.
- R8: int_req is high exactly while some source is pending and enabled. The enable register at address 3, bits 3..0 (same order), resets to 4'b1111.
- R9: An acknowledge is a cycle with iorq_n and m1_n both low after a cycle in which they were not both low. A strobe held low for many cycles counts once, and vec_out changes only at that edge.
- R10: The fixed raster event fires on every 52nd line_start after frame_start and sets raster pending.
- R11: A nonzero line number L at address 1 sets raster pending on the (L+1)th line_start after frame_start. L = 0 disables the programmable event.
- R12: A request arriving in the same cycle as a clear of the same flag, by acknowledge or by write, leaves the flag set.
- R13: Reset (synchronous, active high) clears pending flags, the vector register, the serviced log, vec_out and int_req, and sets all enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 vector, 1 line, 2 status, 3 enable) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| dma_req | input | 3 | One-cycle completion pulses from DMA channels 2..0 |
| line_start | input | 1 | One-cycle pulse at each new video line |
| frame_start | input | 1 | One-cycle pulse at the top of a frame |
| iorq_n | input | 1 | CPU I/O request strobe, active low |
| m1_n | input | 1 | CPU opcode-fetch strobe, active low |
| int_req | output | 1 | Interrupt request to the CPU, active high |
| vec_out | output | 8 | Vector captured at the last acknowledge |

## Verification
Two functions can fall in the same cycle: the clear of a pending flag, by an auto-clear acknowledge or by a status write, and a new request for that same flag. The bench forces this by pulsing a DMA request on the exact clock edge where the strobes first go low, and again on the edge of a clearing status write. The next status read must show the flag still set. For the acknowledge case, the vector and serviced log must still name that source. A long acknowledge strobe is held over pending patterns that contain two sources, so that a second, false acknowledge would show up as an extra cleared flag.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] REG_VEC  = 2'd0;
  localparam logic [1:0] REG_LINE = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_EN   = 2'd3;
endpackage

// File: rtl/irq_raster_gen.sv
module irq_raster_gen #(
  parameter int unsigned LINE_W       = 8,
  parameter int unsigned FIXED_PERIOD = 52
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic [LINE_W-1:0] line_cmp,
  output logic              raster_evt
);
  localparam int unsigned CNT_W = $clog2(FIXED_PERIOD);

  logic [LINE_W-1:0] line_num;
  logic [CNT_W-1:0]  fix_cnt;
  logic              fix_hit, prog_hit;

  assign fix_hit  = (fix_cnt == CNT_W'(FIXED_PERIOD - 1));
  assign prog_hit = (line_cmp != '0) && (line_num == line_cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_num   <= '0;
      fix_cnt    <= '0;
      raster_evt <= 1'b0;
    end else if (frame_start) begin
      line_num   <= '0;
      fix_cnt    <= '0;
      raster_evt <= 1'b0;
    end else if (line_start) begin
      line_num   <= line_num + 1'b1;
      fix_cnt    <= fix_hit ? '0 : fix_cnt + 1'b1;
      raster_evt <= fix_hit | prog_hit;
    end else begin
      raster_evt <= 1'b0;
    end
  end

  // R10
  fix_range_chk: assert property (@(posedge clk) disable iff (rst)
    fix_cnt < CNT_W'(FIXED_PERIOD));
endmodule

// File: rtl/irq_ack_detect.sv
module irq_ack_detect (
  input  logic clk,
  input  logic rst,
  input  logic iorq_n,
  input  logic m1_n,
  output logic ack_pulse
);
  logic both_low, both_low_q;

  assign both_low  = ~iorq_n & ~m1_n;
  assign ack_pulse = both_low & ~both_low_q;

  always_ff @(posedge clk) begin
    if (rst) both_low_q <= 1'b0;
    else     both_low_q <= both_low;
  end

  // R9
  single_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |=> !ack_pulse);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  assign any = |req;

  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == N - 1) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_low
      assign grant[i] = req[i] & ~(|req[N-1:i+1]);
    end
  end

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~req) == '0));
  // R3
  grant_any_chk: assert property (@(posedge clk) disable iff (rst)
    any |-> $countones(grant) == 1);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_DMA      = 3,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CODE_W       = 3,
  parameter int unsigned LINE_W       = 8,
  parameter int unsigned FIXED_PERIOD = 52
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_DMA-1:0] dma_req,
  input  logic               line_start,
  input  logic               frame_start,
  input  logic               iorq_n,
  input  logic               m1_n,
  output logic               int_req,
  output logic [DATA_W-1:0]  vec_out
);
  localparam int unsigned NUM_SRC = NUM_DMA + 1;
  localparam int unsigned HI_W    = DATA_W - 1 - CODE_W;

  function automatic logic [CODE_W-1:0] src_code(input int unsigned idx);
    if (idx == NUM_DMA) return CODE_W'(NUM_DMA);
    return CODE_W'(NUM_DMA - 1 - idx);
  endfunction

  logic [NUM_SRC-1:0] pending, enable, serv_log;
  logic [NUM_SRC-1:0] set_vec, grant, serviced, clr_sw, clr_ack, pend_nxt, en_nxt;
  logic [HI_W-1:0]    vec_hi;
  logic               vec_mode;
  logic [LINE_W-1:0]  line_cmp;
  logic [CODE_W-1:0]  code_sel;
  logic               raster_evt, ack_pulse, any_req;
  logic               wr_vec, wr_line, wr_stat, wr_en;

  irq_raster_gen #(.LINE_W(LINE_W), .FIXED_PERIOD(FIXED_PERIOD)) u_raster (
    .clk(clk), .rst(rst), .line_start(line_start), .frame_start(frame_start),
    .line_cmp(line_cmp), .raster_evt(raster_evt));

  irq_ack_detect u_ack (
    .clk(clk), .rst(rst), .iorq_n(iorq_n), .m1_n(m1_n), .ack_pulse(ack_pulse));

  irq_prio_pick #(.N(NUM_SRC)) u_pick (
    .clk(clk), .rst(rst), .req(pending & enable), .grant(grant), .any(any_req));

  assign set_vec  = {raster_evt, dma_req};
  assign serviced = any_req ? grant : NUM_SRC'(1);

  always_comb begin
    code_sel = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (serviced[i]) code_sel = code_sel | src_code(i);
  end

  assign wr_vec  = reg_we && (reg_addr == REG_VEC);
  assign wr_line = reg_we && (reg_addr == REG_LINE);
  assign wr_stat = reg_we && (reg_addr == REG_STAT);
  assign wr_en   = reg_we && (reg_addr == REG_EN);

  assign clr_sw   = wr_stat ? reg_wdata[NUM_SRC-1:0] : '0;
  assign clr_ack  = (ack_pulse && !vec_mode) ? serviced : '0;
  assign pend_nxt = (pending & ~(clr_sw | clr_ack)) | set_vec;
  assign en_nxt   = wr_en ? reg_wdata[NUM_SRC-1:0] : enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      enable    <= '1;
      serv_log  <= '0;
      vec_hi    <= '0;
      vec_mode  <= 1'b0;
      line_cmp  <= '0;
      vec_out   <= '0;
      int_req   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      pending <= pend_nxt;
      enable  <= en_nxt;
      int_req <= |(pend_nxt & en_nxt);
      if (wr_vec) begin
        vec_hi   <= reg_wdata[DATA_W-1 -: HI_W];
        vec_mode <= reg_wdata[0];
      end
      if (wr_line) line_cmp <= reg_wdata[LINE_W-1:0];
      if (ack_pulse) begin
        vec_out  <= {vec_hi, code_sel, 1'b0};
        serv_log <= serviced;
      end
      case (reg_addr)
        REG_VEC:  reg_rdata <= {vec_hi, CODE_W'(0), vec_mode};
        REG_LINE: reg_rdata <= DATA_W'(line_cmp);
        REG_STAT: reg_rdata <= DATA_W'({serv_log, pending});
        default:  reg_rdata <= DATA_W'(enable);
      endcase
    end
  end

  // R5
  autoclr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_pulse && !vec_mode && ((set_vec & serviced) == '0))
      |=> ((pending & $past(serviced)) == '0));
  // R6
  manual_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_pulse && vec_mode && !wr_stat) |=> ((pending & $past(pending)) == $past(pending)));
  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    int_req == |(pending & enable));
  // R9
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_pulse |=> $stable(vec_out));
  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((pending & $past(set_vec)) == $past(set_vec)));
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [2:0] dma_req = 3'd0;
  logic       line_start = 1'b0, frame_start = 1'b0;
  logic       iorq_n = 1'b1, m1_n = 1'b1;
  logic       int_req;
  logic [7:0] vec_out;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
    .line_start(line_start), .frame_start(frame_start), .iorq_n(iorq_n),
    .m1_n(m1_n), .int_req(int_req), .vec_out(vec_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_start = 1'b1;
      @(negedge clk); line_start = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic load(input logic [3:0] p);
    wr(2'd2, 8'h0F);
    if (p[3]) begin
      wr(2'd1, 8'd1);
      frame();
      lines(2);
    end
    @(negedge clk); dma_req = p[2:0];
    @(negedge clk); dma_req = 3'd0;
  endtask

  task automatic ack(input int hold);
    @(negedge clk); iorq_n = 1'b0; m1_n = 1'b0;
    repeat (hold) @(negedge clk);
    iorq_n = 1'b1; m1_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [2:0] exp_code(input logic [3:0] p);
    if (p[3]) return 3'b011;
    if (p[2]) return 3'b000;
    if (p[1]) return 3'b001;
    return 3'b010;
  endfunction

  function automatic logic [3:0] exp_serv(input logic [3:0] p);
    if (p[3]) return 4'b1000;
    if (p[2]) return 4'b0100;
    if (p[1]) return 4'b0010;
    return 4'b0001;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, ev;
    logic [3:0] hi, sv, pe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(int_req == 1'b0, "R13 int_req", int_req, 0);
    check(vec_out == 8'h00, "R13 vec_out", vec_out, 0);
    rd(2'd0, d); check(d == 8'h00, "R13 vector reg", d, 0);
    rd(2'd2, d); check(d == 8'h00, "R13 status", d, 0);
    rd(2'd3, d); check(d == 8'h0F, "R8 R13 enable reset", d, 8'h0F);

    // Sweep of every pending pattern under both clear modes
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 16; p++) begin
        hi = 4'((p * 3 + m) & 15);
        wr(2'd0, {hi, 3'b000, 1'(m)});
        load(4'(p));
        rd(2'd2, d);
        check(d[3:0] == 4'(p), "R7 R10 pending before ack", d, p);
        check(int_req == (p != 0), "R8 int_req level", int_req, (p != 0));
        ack(3);
        ev = {hi, exp_code(4'(p)), 1'b0};
        check(vec_out == ev, "R1 R2 R3 R4 R9 vector", vec_out, ev);
        sv = (p == 0) ? 4'b0001 : exp_serv(4'(p));
        pe = (m == 0) ? (4'(p) & ~sv) : 4'(p);
        rd(2'd2, d);
        check(d == {sv, pe}, (m == 0) ? "R5 R9 status after ack" : "R6 R7 status after ack",
              d, {sv, pe});
      end
    end

    // R6 manual write clear: ones clear, zeros keep
    wr(2'd0, 8'h01);
    load(4'hF);
    wr(2'd2, 8'h05);
    rd(2'd2, d); check(d[3:0] == 4'hA, "R6 write-one clear", d[3:0], 4'hA);
    wr(2'd2, 8'h00);
    rd(2'd2, d); check(d[3:0] == 4'hA, "R6 write-zero no effect", d[3:0], 4'hA);

    // R8 R4 enable mask
    wr(2'd0, 8'h90);
    wr(2'd3, 8'h00);
    load(4'h2);
    check(int_req == 1'b0, "R8 masked source", int_req, 0);
    ack(1);
    check(vec_out == 8'h94, "R4 default vector when masked", vec_out, 8'h94);
    rd(2'd2, d); check(d == 8'h12, "R4 R5 masked source untouched", d, 8'h12);
    wr(2'd3, 8'h02);
    @(negedge clk);
    check(int_req == 1'b1, "R8 unmask raises request", int_req, 1);
    wr(2'd3, 8'h0F);

    // R10 fixed event and R11 disabled programmable event
    wr(2'd1, 8'd0);
    wr(2'd2, 8'h0F);
    frame();
    lines(51);
    rd(2'd2, d); check(d[3] == 1'b0, "R10 R11 no raster before 52", d[3], 0);
    lines(1);
    rd(2'd2, d); check(d[3] == 1'b1, "R10 raster at line 52", d[3], 1);

    // R11 programmable line
    wr(2'd1, 8'd5);
    wr(2'd2, 8'h0F);
    frame();
    lines(5);
    rd(2'd2, d); check(d[3] == 1'b0, "R11 not yet", d[3], 0);
    lines(1);
    rd(2'd2, d); check(d[3] == 1'b1, "R11 line match", d[3], 1);

    // R12 acknowledge clear and new request in the same cycle
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h0F);
    @(negedge clk); dma_req = 3'b010;
    @(negedge clk); dma_req = 3'b010; iorq_n = 1'b0; m1_n = 1'b0;
    @(negedge clk); dma_req = 3'b000; iorq_n = 1'b1; m1_n = 1'b1;
    check(vec_out == 8'h02, "R12 vector of colliding source", vec_out, 8'h02);
    rd(2'd2, d); check(d == 8'h22, "R12 set wins over ack clear", d, 8'h22);

    // R12 status write clear and new request in the same cycle
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h02; dma_req = 3'b010;
    @(negedge clk); reg_we = 1'b0; dma_req = 3'b000;
    rd(2'd2, d); check(d[1] == 1'b1, "R12 set wins over write clear", d[1], 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule